// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise Rejection

This block receives asynchronous serial frames from a single line. The line is synchronised into the clock domain and sampled once per pulse of an external oversampling tick. A falling edge of the line opens a frame, and the middle of every bit is decided by a three-sample majority vote, so short spikes on the line do not change a bit. A start bit that no longer reads low at its midpoint is discarded as noise, and the receiver goes back to waiting for the next edge.

The frame carries 5 to 9 data bits, least significant bit first, then an optional parity bit and one or more stop bits. A finished word is placed in a one-entry holding register with a valid flag. Flags for framing error, parity error and overrun come with the word and are cleared when the word is read. An address-filter mode drops every frame whose ninth bit is clear, so a listener on a shared line wakes only for address frames. Baud-rate division is done outside the block. The tick must pulse 16 times per bit period, or 8 times in fast mode.

Top module: `serial_rx_filter`

## Requirements
- R1: After reset `rd_valid`, `rd_frame_err`, `rd_par_err` and `rd_overrun` are 0 and the receiver waits for a falling edge.
- R2: `cfg_bits` selects the data length. Values 5..9 are used as given, values below 5 act as 5 and values above 9 act as 9. The first received bit lands in `rd_data[0]`, unused upper bits of `rd_data` are 0, and `rd_valid` rises once the word is stored.
- R3: With `cfg_fast`=0 a bit spans 16 ticks and its value is the majority of ticks 8, 9 and 10 counted from the detected edge. With `cfg_fast`=1 a bit spans 8 ticks and ticks 4, 5 and 6 are voted. A spike lasting one tick inside a bit does not alter the bit.
- R4: A low pulse that has ended by the middle of the start bit produces no word. The next genuine frame is still received correctly.
- R5: With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `rd_par_err` with the word. With `cfg_par_en`=0 no parity bit is expected and `rd_par_err` stays 0.
- R6: A first stop bit that votes low sets `rd_frame_err`, and the word is still delivered.
- R7: Only the first stop bit is examined. The receiver is ready again from the middle of that bit, so a start bit may follow a single stop bit directly, and any further stop bits are accepted as idle line.
- R8: When a word completes while `rd_valid` is 1 and no read is strobed in that cycle, the held word and its flags are kept, the new word is lost and `rd_overrun` is set.
- R9: A one-cycle `rd_ack` while `rd_valid` is 1 clears `rd_valid` and all three flags. `rd_ack` while `rd_valid` is 0 changes nothing.
- R10: With `cfg_addr_filter`=1 a finished frame is stored only if data bit 8 is 1. Frames with bit 8 at 0 are dropped, and this includes every frame shorter than 9 bits. With the mode off, all frames are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| cfg_bits | input | 4 | Data bits per frame |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_fast | input | 1 | 8 ticks per bit instead of 16 |
| cfg_addr_filter | input | 1 | Drop frames whose bit 8 is 0 |
| rd_ack | input | 1 | Read strobe for the holding register |
| rd_data | output | 9 | Received word, right aligned |
| rd_valid | output | 1 | Word waiting to be read |
| rd_frame_err | output | 1 | Framing error of the held word |
| rd_par_err | output | 1 | Parity error of the held word |
| rd_overrun | output | 1 | A later word was lost |

## Verification
The bench builds the block with the default 16-tick bit and a two-stage synchroniser, and drives a tick on every second clock. Every frame therefore lasts at most a few hundred cycles, which makes it possible to sweep every data length from 5 to 9, all three parity settings and both speeds against arithmetic expectations. At that size, a spike can be injected into the voting window of every data bit, and the false-start, framing, overrun, back-to-back and address-filter cases each get their own frames.

// File: rtl/srxf_pkg.sv
package srxf_pkg;

  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // majority of three samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // first voted tick inside a bit of osr ticks
  function automatic int vote_first(input int osr);
    return osr / 2;
  endfunction

  // clamp the configured length into the legal range
  function automatic logic [3:0] eff_bits(input logic [3:0] req);
    if (req < 4'(MIN_BITS)) return 4'(MIN_BITS);
    if (req > 4'(MAX_BITS)) return 4'(MAX_BITS);
    return req;
  endfunction

  // bits enter at the top of the shift register; move them down to bit 0
  function automatic logic [MAX_BITS-1:0] right_align(input logic [MAX_BITS-1:0] sh,
                                                      input logic [3:0] n);
    return sh >> (MAX_BITS - int'(n));
  endfunction

  // 1 when data plus parity bit disagree with the selected sense
  function automatic logic parity_bad(input logic [MAX_BITS-1:0] d, input logic p,
                                      input logic odd);
    return ((^d) ^ p) != odd;
  endfunction

endpackage

// File: rtl/srxf_sync.sv
module srxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srxf_bit_timer.sv
module srxf_bit_timer
  import srxf_pkg::*;
#(
  parameter int OSR_NORMAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic fast,
  input  logic busy,
  output logic start_evt,
  output logic mid_evt,
  output logic mid_val
);
  localparam int OSR_FAST = OSR_NORMAL / 2;
  localparam int CW       = $clog2(OSR_NORMAL + 1);
  localparam logic [CW-1:0] N_TOP   = CW'(OSR_NORMAL);
  localparam logic [CW-1:0] F_TOP   = CW'(OSR_FAST);
  localparam logic [CW-1:0] N_FIRST = CW'(vote_first(OSR_NORMAL));
  localparam logic [CW-1:0] F_FIRST = CW'(vote_first(OSR_FAST));
  localparam logic [CW-1:0] N_LAST  = CW'(vote_first(OSR_NORMAL) + 2);
  localparam logic [CW-1:0] F_LAST  = CW'(vote_first(OSR_FAST) + 2);

  logic [CW-1:0] samp_q;
  logic [CW-1:0] top, first, last;
  logic [1:0]    votes_q;
  logic          rx_prev_q;
  logic          in_window;

  assign top       = fast ? F_TOP   : N_TOP;
  assign first     = fast ? F_FIRST : N_FIRST;
  assign last      = fast ? F_LAST  : N_LAST;
  assign in_window = (samp_q >= first) && (samp_q < last);

  // edge seen between two successive ticks while no frame is open
  assign start_evt = tick & ~busy & rx_prev_q & ~rx_s;
  assign mid_evt   = tick & busy & (samp_q == last);
  assign mid_val   = maj3(votes_q[1], votes_q[0], rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q <= 1'b1;
      samp_q    <= CW'(1);
      votes_q   <= 2'b11;
    end else begin
      if (tick) rx_prev_q <= rx_s;
      if (start_evt) begin
        samp_q <= CW'(2);
      end else if (!busy) begin
        samp_q <= CW'(1);
      end else if (tick) begin
        if (in_window) votes_q <= {votes_q[0], rx_s};
        samp_q <= (samp_q == top) ? CW'(1) : samp_q + 1'b1;
      end
    end
  end

  AST_SAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (samp_q >= CW'(1) && samp_q <= top)); // R3
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && samp_q == CW'(2))); // R4
endmodule

// File: rtl/srxf_frame.sv
module srxf_frame
  import srxf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_evt,
  input  logic                mid_evt,
  input  logic                mid_val,
  input  logic [3:0]          cfg_bits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] done_data,
  output logic                done_ferr,
  output logic                done_perr
);
  rx_state_e           state_q;
  logic [MAX_BITS-1:0] shift_q;
  logic [3:0]          cnt_q;
  logic [3:0]          nbits;
  logic                pbit_q;
  logic                last_data;
  logic [MAX_BITS-1:0] aligned;

  assign nbits     = eff_bits(cfg_bits);
  assign last_data = (cnt_q == nbits - 4'd1);
  assign aligned   = right_align(shift_q, nbits);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      cnt_q     <= '0;
      pbit_q    <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      done_ferr <= 1'b0;
      done_perr <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_evt) state_q <= ST_START;
        ST_START: if (mid_evt) begin
          cnt_q   <= '0;
          state_q <= mid_val ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (mid_evt) begin
          shift_q <= {mid_val, shift_q[MAX_BITS-1:1]};
          cnt_q   <= cnt_q + 4'd1;
          if (last_data) state_q <= cfg_par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (mid_evt) begin
          pbit_q  <= mid_val;
          state_q <= ST_STOP;
        end
        ST_STOP: if (mid_evt) begin
          done      <= 1'b1;
          done_data <= aligned;
          done_ferr <= ~mid_val;
          done_perr <= cfg_par_en & parity_bad(aligned, pbit_q, cfg_par_odd);
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && mid_evt && mid_val) |=> (!busy && !done)); // R4
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cfg_par_en)) |-> !done_perr); // R5
endmodule

// File: rtl/srxf_hold.sv
module srxf_hold
  import srxf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic                in_ferr,
  input  logic                in_perr,
  input  logic                addr_filter,
  input  logic                rd_ack,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_frame_err,
  output logic                rd_par_err,
  output logic                rd_overrun
);
  logic accept;
  logic lost;

  assign accept = done & (~addr_filter | in_data[MAX_BITS-1]);
  assign lost   = accept & rd_valid & ~rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      rd_valid     <= 1'b0;
      rd_frame_err <= 1'b0;
      rd_par_err   <= 1'b0;
      rd_overrun   <= 1'b0;
    end else if (lost) begin
      rd_overrun <= 1'b1;
    end else if (accept) begin
      rd_data      <= in_data;
      rd_valid     <= 1'b1;
      rd_frame_err <= in_ferr;
      rd_par_err   <= in_perr;
      rd_overrun   <= 1'b0;
    end else if (rd_ack && rd_valid) begin
      rd_valid     <= 1'b0;
      rd_frame_err <= 1'b0;
      rd_par_err   <= 1'b0;
      rd_overrun   <= 1'b0;
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data))); // R8
  AST_OVR_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_overrun |-> rd_valid); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && rd_valid && !done) |=> (!rd_valid && !rd_overrun && !rd_frame_err && !rd_par_err)); // R9
  AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && addr_filter && !in_data[MAX_BITS-1] && !rd_valid) |=> !rd_valid); // R10
endmodule

// File: rtl/serial_rx_filter.sv
module serial_rx_filter
  import srxf_pkg::*;
#(
  parameter int OSR_NORMAL  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in,
  input  logic                os_tick,
  input  logic [3:0]          cfg_bits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_fast,
  input  logic                cfg_addr_filter,
  input  logic                rd_ack,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_frame_err,
  output logic                rd_par_err,
  output logic                rd_overrun
);
  logic                rx_s;
  logic                busy;
  logic                start_evt;
  logic                mid_evt;
  logic                mid_val;
  logic                done;
  logic [MAX_BITS-1:0] done_data;
  logic                done_ferr;
  logic                done_perr;

  srxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  srxf_bit_timer #(.OSR_NORMAL(OSR_NORMAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .fast(cfg_fast),
    .busy(busy), .start_evt(start_evt), .mid_evt(mid_evt), .mid_val(mid_val)
  );

  srxf_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .mid_evt(mid_evt),
    .mid_val(mid_val), .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .busy(busy), .done(done), .done_data(done_data),
    .done_ferr(done_ferr), .done_perr(done_perr)
  );

  srxf_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done(done), .in_data(done_data),
    .in_ferr(done_ferr), .in_perr(done_perr), .addr_filter(cfg_addr_filter),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err), .rd_overrun(rd_overrun)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && eff_bits(cfg_bits) == 4'd5) |-> (rd_data[MAX_BITS-1:5] == '0)); // R2
endmodule

// File: tb/serial_rx_filter_bench.sv
module serial_rx_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic [3:0] nbits;
  logic       par_en, par_odd, fast, afilt, rd;
  logic [8:0] data;
  logic       valid, ferr, perr, ovr;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  serial_rx_filter u_serial_rx_filter (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .os_tick(tick), .cfg_bits(nbits),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_fast(fast),
    .cfg_addr_filter(afilt), .rd_ack(rd), .rd_data(data), .rd_valid(valid),
    .rd_frame_err(ferr), .rd_par_err(perr), .rd_overrun(ovr)
  );

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ticks_per_bit(input bit f);
    return f ? 8 : 16;
  endfunction

  // hold one bit on the line; optional one-tick spike in its voting window
  task automatic put_bit(input bit v, input bit spike);
    int cyc = 2 * ticks_per_bit(fast);
    if (spike) begin
      rx = v;
      repeat (cyc / 2) @(negedge clk);
      rx = ~v;
      repeat (2) @(negedge clk);
      rx = v;
      repeat (cyc / 2 - 2) @(negedge clk);
    end else begin
      rx = v;
      repeat (cyc) @(negedge clk);
    end
  endtask

  task automatic send(input int v, input int n, input bit stop_v, input bit flip,
                      input bit spike, input int idle_bits);
    int m = (1 << n) - 1;
    put_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) put_bit(((v >> i) & 1) != 0, spike);
    if (par_en) put_bit((^(v & m)) ^ par_odd ^ flip, 1'b0);
    put_bit(stop_v, 1'b0);
    rx = 1'b1;
    repeat (idle_bits * 2 * ticks_per_bit(fast)) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_word(input string req, input int d, input bit fe, input bit pe,
                             input bit ov);
    chk(req, "valid", int'(valid), 1);
    chk(req, "data", int'(data), d);
    chk(req, "frame_err", int'(ferr), int'(fe));
    chk(req, "par_err", int'(perr), int'(pe));
    chk(req, "overrun", int'(ovr), int'(ov));
  endtask

  task automatic expect_empty(input string req);
    chk(req, "valid", int'(valid), 0);
    chk(req, "flags", int'({ferr, perr, ovr}), 0);
  endtask

  initial begin
    #(8 * 195000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pats[4];
    rst_n = 1'b0; rx = 1'b1; rd = 1'b0; nbits = 4'd8;
    par_en = 1'b0; par_odd = 1'b0; fast = 1'b0; afilt = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    expect_empty("R1");

    // R2 R3 R5 sweep: lengths, parity modes, both speeds
    pats[0] = 'h000; pats[1] = 'h1ff; pats[2] = 'h155; pats[3] = 'h0b3;
    for (int f = 0; f < 2; f++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int n = 5; n <= 9; n++) begin
          for (int k = 0; k < 4; k++) begin
            fast = f[0]; par_en = (pm != 0); par_odd = (pm == 2); nbits = 4'(n);
            send(pats[k], n, 1'b1, 1'b0, (k == 3), 1);
            expect_word("R2", pats[k] & ((1 << n) - 1), 1'b0, 1'b0, 1'b0);
            do_read();
          end
        end
      end
    end

    // R2 clamped lengths: 3 acts as 5, 12 acts as 9
    fast = 1'b0; par_en = 1'b0; nbits = 4'd3;
    send('h1f, 5, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R2", 'h1f, 1'b0, 1'b0, 1'b0);
    do_read();
    nbits = 4'd12;
    send('h1a5, 9, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R2", 'h1a5, 1'b0, 1'b0, 1'b0);
    do_read();

    // R5 parity mismatch, even and odd
    nbits = 4'd8; par_en = 1'b1;
    for (int po = 0; po < 2; po++) begin
      par_odd = po[0];
      send('h6c, 8, 1'b1, 1'b1, 1'b0, 1);
      expect_word("R5", 'h6c, 1'b0, 1'b1, 1'b0);
      do_read();
      // R9 flags cleared by the read
      expect_empty("R9");
    end
    par_en = 1'b0;

    // R4 false start, then a real frame
    for (int f = 0; f < 2; f++) begin
      fast = f[0];
      rx = 1'b0;
      repeat (ticks_per_bit(fast) / 2) @(negedge clk);
      rx = 1'b1;
      repeat (6 * ticks_per_bit(fast)) @(negedge clk);
      expect_empty("R4");
      send('h3c, 8, 1'b1, 1'b0, 1'b0, 1);
      expect_word("R4", 'h3c, 1'b0, 1'b0, 1'b0);
      do_read();
    end
    fast = 1'b0;

    // R6 framing error, word still delivered
    send('h81, 8, 1'b0, 1'b0, 1'b0, 2);
    expect_word("R6", 'h81, 1'b1, 1'b0, 1'b0);
    do_read();
    expect_empty("R9");

    // R7 R8 back-to-back after a single stop bit, second frame overruns
    send('h5a, 8, 1'b1, 1'b0, 1'b0, 0);
    send('ha5, 8, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R8", 'h5a, 1'b0, 1'b0, 1'b1);
    do_read();
    expect_empty("R7");

    // R9 read while empty changes nothing
    do_read();
    expect_empty("R9");
    send('h42, 8, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R9", 'h42, 1'b0, 1'b0, 1'b0);
    do_read();

    // R10 address filter
    afilt = 1'b1; nbits = 4'd9;
    send('h0aa, 9, 1'b1, 1'b0, 1'b0, 1);
    expect_empty("R10");
    nbits = 4'd8;
    send('hff, 8, 1'b1, 1'b0, 1'b0, 1);
    expect_empty("R10");
    nbits = 4'd9;
    send('h1aa, 9, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R10", 'h1aa, 1'b0, 1'b0, 1'b0);
    do_read();
    afilt = 1'b0;
    send('h0aa, 9, 1'b1, 1'b0, 1'b0, 1);
    expect_word("R10", 'h0aa, 1'b0, 1'b0, 1'b0);
    do_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule